// File: doc/BRIEF.md
# Reversible bidirectional ripple-carry adder

This block is a combinational ripple-carry adder of parameterised width, built only from self-inverse reversible gates: controlled-NOT (the control is XORed onto a target) and controlled-swap (two targets exchange when the control is 1). No information is lost anywhere in the network. Each bit below the top one has an upward cell, which carries the majority toward the top bit, and a downward cell, which undoes that majority and rebuilds the carry on the way back. The top bit uses two controlled-NOT gates and nothing else, and there is no carry-out.

A single direction input selects the mode. In add mode the operands `x_in` (a), `y_in` (b) and `c_in` (carry) produce a copy of a on `x_out`, the wrapped sum on `y_out`, and the restored carry on `c_out`. In subtract mode the same gates are applied in reverse order. The copy of a, the sum and the carry then go in, and a, the difference and the carry come out. Feeding an add result into a second instance set to subtract returns the original operands exactly.

Top module: `rev_ripple_adder`

## Requirements
- R1: With `mode_sub` = 0, `y_out` equals (`x_in` + `y_in` + `c_in`) modulo 2^WIDTH; e.g. 0110 + 0110 + 1 gives 1101.
- R2: With `mode_sub` = 1, `y_out` equals (`y_in` − `x_in` − `c_in`) modulo 2^WIDTH; e.g. `y_in` = 0110, `x_in` = 0101, `c_in` = 0 gives 0001.
- R3: `c_out` equals `c_in` in both modes, so the carry is always restored.
- R4: `x_out` equals `x_in` in both modes, and its top bit is a direct pass-through of the top bit of `x_in`.
- R5: An add-mode instance feeding `x_out`, `y_out` and `c_out` straight into a subtract-mode instance returns the original `x_in`, `y_in` and `c_in` for every combination of operands and carry.
- R6: No carry-out exists, so the sum wraps: 1111 + 0001 + 0 gives 0000, and 1111 + 1111 + 1 gives 1111.
- R7: The block is purely combinational. Changing `mode_sub` while the data inputs stay the same changes `y_out` with no clock; with `x_in` = 0011, `y_in` = 0100 and `c_in` = 0, `y_out` is 0111 in add mode and 0001 in subtract mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_sub | input | 1 | 0 selects add, 1 selects subtract (reverse gate order) |
| x_in | input | WIDTH | Operand a in add mode; copy of a in subtract mode |
| y_in | input | WIDTH | Operand b in add mode; sum in subtract mode |
| c_in | input | 1 | Carry in add mode; restored carry in subtract mode |
| x_out | output | WIDTH | Copy of a (add) or recovered a (subtract) |
| y_out | output | WIDTH | Sum (add) or difference b (subtract) |
| c_out | output | 1 | Restored carry, equal to `c_in` |

## Verification
Addition and its exact undoing happen in the same evaluation when one instance in add mode drives a second instance fixed in subtract mode. All 512 operand and carry combinations are swept through this pair. In each step the sum, the copy and the carry of the first instance are compared with arithmetic, and the outputs of the second are compared with the original operands. A direction flip with the data held steady checks that both readings of the same inputs come out of the same network without a clock.

// File: rtl/rrca_pkg.sv
package rrca_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Two wires that a controlled-swap may exchange.
   typedef struct packed {
      logic lo;
      logic hi;
   } swap_pair_t;

   // Controlled-NOT: target XOR control. It is its own inverse.
   function automatic logic cnot(input logic ctl, input logic tgt);
      return tgt ^ ctl;
   endfunction

   // Controlled-swap: exchange lo and hi when ctl is 1. It is its own inverse.
   function automatic swap_pair_t cswap(input logic ctl, input logic lo, input logic hi);
      swap_pair_t r;
      r.lo = ctl ? hi : lo;
      r.hi = ctl ? lo : hi;
      return r;
   endfunction
endpackage

// File: rtl/rrca_up_cell.sv
// Upward cell of one low bit. In add mode it is the majority stage:
// CNOT(a->b), then swap(a,carry) under the new b. In subtract mode it is
// the undo stage run backwards: CNOT(carry->sum), then the same swap.
module rrca_up_cell
   import rrca_pkg::*;
(
   input  logic mode_sub,
   input  logic opa,      // a, or copy of a
   input  logic opb,      // b, or sum
   input  logic cy_in,    // carry from the stage below
   output logic cy_out,   // majority carry to the stage above
   output logic mid_x,    // swapped partner kept for the downward cell
   output logic mid_y     // control wire kept for the downward cell
);
   timeunit 1ns;
   timeprecision 1ps;

   logic       ctl_src;
   swap_pair_t sw;

   always_comb begin
      ctl_src = mode_sub ? cy_in : opa;
      mid_y   = cnot(ctl_src, opb);
      sw      = cswap(mid_y, opa, cy_in);
      cy_out  = sw.lo;
      mid_x   = sw.hi;
   end
endmodule

// File: rtl/rrca_down_cell.sv
// Downward cell of one low bit. In add mode it is the unmajority stage:
// swap(carry,partner) under the control wire, then CNOT(carry->control),
// which gives the sum. In subtract mode it is the majority stage run
// backwards: the same swap, then CNOT(a->control), which gives b.
module rrca_down_cell
   import rrca_pkg::*;
(
   input  logic mode_sub,
   input  logic mid_x,
   input  logic mid_y,
   input  logic cy_back_in,   // restored carry from the stage above
   output logic res_x,        // copy of a, or recovered a
   output logic res_y,        // sum, or difference bit
   output logic cy_back_out   // restored carry to the stage below
);
   timeunit 1ns;
   timeprecision 1ps;

   swap_pair_t sw;
   logic       ctl_src;

   always_comb begin
      sw          = cswap(mid_y, cy_back_in, mid_x);
      res_x       = sw.lo;
      cy_back_out = sw.hi;
      ctl_src     = mode_sub ? sw.lo : sw.hi;
      res_y       = cnot(ctl_src, mid_y);
   end
endmodule

// File: rtl/rrca_top_cell.sv
// Top bit: two controlled-NOT gates. The pair commutes, so it reads the
// same in both directions. The a bit passes straight through and the
// carry turns back down the chain.
module rrca_top_cell
   import rrca_pkg::*;
(
   input  logic opa,
   input  logic opb,
   input  logic cy_in,
   output logic res_x,
   output logic res_y,
   output logic cy_back_out
);
   timeunit 1ns;
   timeprecision 1ps;

   always_comb begin
      res_x       = opa;
      res_y       = cnot(cy_in, cnot(opa, opb));
      cy_back_out = cy_in;
   end
endmodule

// File: rtl/rev_ripple_adder.sv
module rev_ripple_adder #(
   parameter int WIDTH = 4
) (
   input  logic             mode_sub,
   input  logic [WIDTH-1:0] x_in,
   input  logic [WIDTH-1:0] y_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] x_out,
   output logic [WIDTH-1:0] y_out,
   output logic             c_out
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LOW_BITS = WIDTH - 1;
   localparam int TOP      = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("rev_ripple_adder: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0]    cy_up;    // majority chain, bit i enters stage i
   logic [WIDTH-1:0]    cy_dn;    // restoring chain, bit i leaves stage i
   logic [LOW_BITS-1:0] keep_x;
   logic [LOW_BITS-1:0] keep_y;

   assign cy_up[0] = c_in;
   assign c_out    = cy_dn[0];

   genvar g;
   generate
      for (g = 0; g < LOW_BITS; g++) begin : g_bit
         rrca_up_cell u_up (
            .mode_sub (mode_sub),
            .opa      (x_in[g]),
            .opb      (y_in[g]),
            .cy_in    (cy_up[g]),
            .cy_out   (cy_up[g+1]),
            .mid_x    (keep_x[g]),
            .mid_y    (keep_y[g])
         );
         rrca_down_cell u_dn (
            .mode_sub    (mode_sub),
            .mid_x       (keep_x[g]),
            .mid_y       (keep_y[g]),
            .cy_back_in  (cy_dn[g+1]),
            .res_x       (x_out[g]),
            .res_y       (y_out[g]),
            .cy_back_out (cy_dn[g])
         );
      end
   endgenerate

   rrca_top_cell u_top (
      .opa         (x_in[TOP]),
      .opb         (y_in[TOP]),
      .cy_in       (cy_up[TOP]),
      .res_x       (x_out[TOP]),
      .res_y       (y_out[TOP]),
      .cy_back_out (cy_dn[TOP])
   );

   // Arithmetic references, independent of the gate network.
   logic [WIDTH-1:0] ref_sum;
   logic [WIDTH-1:0] ref_diff;
   assign ref_sum  = x_in + y_in + {{(WIDTH-1){1'b0}}, c_in};
   assign ref_diff = y_in - x_in - {{(WIDTH-1){1'b0}}, c_in};

   always_comb begin
      if (!mode_sub) begin
         a_r1_fwd_sum: assert (y_out == ref_sum)
            else $error("R1: sum from gate network disagrees with arithmetic");
      end else begin
         a_r2_bwd_diff: assert (y_out == ref_diff)
            else $error("R2: difference from gate network disagrees with arithmetic");
      end
      a_r3_carry_restored: assert (c_out == c_in)
         else $error("R3: carry not restored");
      a_r4_copy_kept: assert (x_out == x_in)
         else $error("R4: copy of a corrupted");
      a_r4_top_passthru: assert (x_out[TOP] == x_in[TOP])
         else $error("R4: top bit of a not passed through");
   end
endmodule

// File: tb/rev_ripple_adder_tb.sv
module rev_ripple_adder_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int W = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;   // 100 MHz

   logic         rst_n;
   logic         mode_sub;
   logic [W-1:0] x_in, y_in;
   logic         c_in;
   logic [W-1:0] x_out, y_out;
   logic         c_out;
   logic [W-1:0] bx_out, by_out;
   logic         bc_out;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   rev_ripple_adder #(.WIDTH(W)) u_dut (
      .mode_sub (mode_sub), .x_in (x_in), .y_in (y_in), .c_in (c_in),
      .x_out (x_out), .y_out (y_out), .c_out (c_out)
   );

   // Second instance fixed to subtract, fed by the first (round trip).
   rev_ripple_adder #(.WIDTH(W)) u_back (
      .mode_sub (1'b1), .x_in (x_out), .y_in (y_out), .c_in (c_out),
      .x_out (bx_out), .y_out (by_out), .c_out (bc_out)
   );

   typedef struct packed {
      logic         d;
      logic [W-1:0] x;
      logic [W-1:0] y;
      logic         c;
      logic [W-1:0] e;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t TBL [NV] = '{
      {1'b0, 4'b0110, 4'b0110, 1'b1, 4'b1101},   // R1 worked example
      {1'b1, 4'b0101, 4'b0110, 1'b0, 4'b0001},   // R2 worked example
      {1'b0, 4'b1111, 4'b0001, 1'b0, 4'b0000},   // R6 wrap
      {1'b0, 4'b1111, 4'b1111, 1'b1, 4'b1111},   // R6 all ones
      {1'b1, 4'b0001, 4'b0000, 1'b0, 4'b1111},   // R2 borrow wrap
      {1'b0, 4'b0000, 4'b0000, 1'b0, 4'b0000},   // R1 zeros
      {1'b1, 4'b0000, 4'b0000, 1'b1, 4'b1111},   // R2 carry only
      {1'b0, 4'b1010, 4'b0101, 1'b1, 4'b0000},   // R6 exact 2^W
      {1'b1, 4'b1000, 4'b1000, 1'b1, 4'b1111}    // R2 equal operands
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic d, input logic [W-1:0] x,
                        input logic [W-1:0] y, input logic c);
      @(negedge clk);
      mode_sub = d; x_in = x; y_in = y; c_in = c;
      #2;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      rst_n = 1'b0;
      mode_sub = 1'b0; x_in = '0; y_in = '0; c_in = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Initial state: all-zero inputs give all-zero outputs (R1, R3, R4).
      drive(1'b0, '0, '0, 1'b0);
      chk("R1 idle sum", int'(y_out), 0);
      chk("R3 idle carry", int'(c_out), 0);
      chk("R4 idle copy", int'(x_out), 0);

      // Table of directed vectors.
      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].d, TBL[i].x, TBL[i].y, TBL[i].c);
         chk(TBL[i].d ? "R2 table diff" : "R1/R6 table sum", int'(y_out), int'(TBL[i].e));
         chk("R3 table carry", int'(c_out), int'(TBL[i].c));
         chk("R4 table copy", int'(x_out), int'(TBL[i].x));
      end

      // R7: direction flip with data held, no clock involved.
      drive(1'b0, 4'b0011, 4'b0100, 1'b0);
      chk("R7 add view", int'(y_out), 7);
      #1 mode_sub = 1'b1;
      #1 chk("R7 sub view", int'(y_out), 1);

      // Exhaustive add mode with round trip.
      for (int v = 0; v < 512; v++) begin
         logic [W-1:0] a, b;
         logic         c;
         a = v[3:0]; b = v[7:4]; c = v[8];
         drive(1'b0, a, b, c);
         chk("R1 sum", int'(y_out), int'(4'(a + b + {3'b000, c})));
         chk("R3 carry", int'(c_out), int'(c));
         chk("R4 copy", int'(x_out), int'(a));
         chk("R4 top bit", int'(x_out[W-1]), int'(a[W-1]));
         chk("R5 trip a", int'(bx_out), int'(a));
         chk("R5 trip b", int'(by_out), int'(b));
         chk("R5 trip c", int'(bc_out), int'(c));
      end

      // Exhaustive subtract mode.
      for (int v = 0; v < 512; v++) begin
         logic [W-1:0] a, s;
         logic         c;
         a = v[3:0]; s = v[7:4]; c = v[8];
         drive(1'b1, a, s, c);
         chk("R2 diff", int'(y_out), int'(4'(s - a - {3'b000, c})));
         chk("R3 carry back", int'(c_out), int'(c));
         chk("R4 a back", int'(x_out), int'(a));
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end
endmodule